// File: doc/BRIEF.md
# Receive Frame Rule-Matching Filter

This block decides, for every received Ethernet frame, whether it is kept or discarded. The frame is presented as a stream of 32-bit words, each with its word index (0 for the first word of every frame) and a flag on the final word. A table of `DEPTH` rules is loaded through a single-cycle host write port. Each rule compares one frame word, at a chosen word offset, against a data value under a byte-granular mask, and may carry a keep flag, a discard flag, or neither.

A pattern whose byte offset is not word aligned is loaded as two rules in adjacent slots. The first slot holds the pattern shifted up by 8·r bits (bits 31..8·r) at word offset floor(offset/4). The second slot holds the remaining low bits (bits 8·r−1..0) at the next word offset, carries the action flags, and is marked as linked to its predecessor. The last table slot is fixed: it matches any frame and keeps it, so unmatched traffic passes. A host that keys a rule to IPv4 frames adds the 14-byte Ethernet header length to the byte offset before splitting.

Rules are evaluated in table order. The lowest-numbered deciding rule that matched in full sets the verdict. The verdict is produced as a one-cycle pulse together with the index of the deciding rule.

Top module: `frame_rule_filter`

## Requirements
- R1: After reset every writable slot is unused and `vd_valid` is low; the first frame after reset is kept with `vd_rule` = DEPTH−1.
- R2: An enabled rule matches a frame word when the word index equals the rule's word offset and `((word ^ data) & mask) == 0`; unmasked bits are ignored.
- R3: When several deciding rules match, the one with the lowest slot index sets the verdict and is reported in `vd_rule`.
- R4: A deciding rule with the discard flag set gives `vd_accept` = 0, even if its keep flag is also set; a rule with only the keep flag gives `vd_accept` = 1.
- R5: A linked rule counts as matched only if it matched and the rule in the slot just below it also matched in the same frame; a linked rule in slot 0 never matches.
- R6: A rule with neither flag set never decides a verdict, even when it matches.
- R7: Slot DEPTH−1 is reserved: host writes to it are ignored, and it matches every frame and keeps it.
- R8: A host write whose word offset exceeds MAX_OFF_BYTES/4 is ignored and leaves the slot unchanged; an offset equal to that limit is accepted.
- R9: A rule whose word offset lies beyond the last word of a frame counts as not matched.
- R10: `vd_valid` pulses high for exactly one cycle, in the cycle after the word flagged as last, with `vd_accept` and `vd_rule` valid in that cycle.
- R11: A host write in the same cycle as a frame word leaves that word compared against the old rule contents. The written slot loses any progress made earlier in the current frame.
- R12: Match progress does not carry from one frame to the next, even when frames follow back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Rule write strobe |
| cfg_addr | input | $clog2(DEPTH) | Slot to write |
| cfg_enable | input | 1 | Slot in use |
| cfg_link | input | 1 | Slot is the second half of a split pair |
| cfg_accept | input | 1 | Keep flag |
| cfg_reject | input | 1 | Discard flag |
| cfg_woff | input | 8 | Word offset within the frame |
| cfg_mask | input | 32 | Compare enable per bit |
| cfg_data | input | 32 | Compare value |
| frm_valid | input | 1 | Frame word present |
| frm_word | input | 32 | Frame word |
| frm_idx | input | 8 | Word index within the frame |
| frm_last | input | 1 | Final word of the frame |
| vd_valid | output | 1 | Verdict strobe |
| vd_accept | output | 1 | 1 keep, 0 discard |
| vd_rule | output | $clog2(DEPTH) | Slot that decided |

## Verification
A host rule write and the final word of a frame can fall in the same cycle. They can also collide on a middle word while the slot being rewritten has already matched earlier words. The bench provokes both cases: it rewrites a keep rule as a discard rule on the last-word cycle and expects the verdict from the old rule, and it rewrites a rule in the middle of a frame and expects the reserved slot to decide. Back-to-back frames provoke the meeting of a verdict pulse with the start of the next frame, and the second frame must not inherit progress from the first.

// File: rtl/frf_pkg.sv
package frf_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 8;

  typedef struct packed {
    logic              en;
    logic              link;
    logic              acc;
    logic              rej;
    logic [IDX_W-1:0]  woff;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] data;
  } rule_t;

  function automatic logic word_hit(rule_t r, logic [DATA_W-1:0] w,
                                    logic [IDX_W-1:0] idx);
    return r.en && (r.woff == idx) && (((w ^ r.data) & r.mask) == '0);
  endfunction
endpackage

// File: rtl/frf_rule_table.sv
module frf_rule_table
  import frf_pkg::*;
#(
  parameter int DEPTH         = 64,
  parameter int MAX_OFF_BYTES = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic              cfg_enable,
  input  logic              cfg_link,
  input  logic              cfg_accept,
  input  logic              cfg_reject,
  input  logic [IDX_W-1:0]  cfg_woff,
  input  logic [DATA_W-1:0] cfg_mask,
  input  logic [DATA_W-1:0] cfg_data,
  output rule_t             rules_o [DEPTH],
  output logic [DEPTH-1:0]  wr_slot_o
);
  localparam int LAST     = DEPTH - 1;
  localparam int MAX_WOFF = MAX_OFF_BYTES / 4;
  localparam rule_t PASS_ALL = '{en: 1'b1, link: 1'b0, acc: 1'b1, rej: 1'b0,
                                 woff: '0, mask: '0, data: '0};

  rule_t tbl_q [LAST];
  logic  wr_ok;
  logic [LAST-1:0] en_vec;

  assign wr_ok = cfg_we && (cfg_addr != AW'(LAST)) &&
                 ({1'b0, cfg_woff} <= (IDX_W+1)'(MAX_WOFF));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAST; i++) tbl_q[i] <= '0;
    end else if (wr_ok) begin
      tbl_q[cfg_addr] <= '{en: cfg_enable, link: cfg_link, acc: cfg_accept,
                           rej: cfg_reject, woff: cfg_woff, mask: cfg_mask,
                           data: cfg_data};
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    if (g == LAST) begin : g_fixed
      assign rules_o[g]   = PASS_ALL;
      assign wr_slot_o[g] = 1'b0;
    end else begin : g_mem
      assign rules_o[g]   = tbl_q[g];
      assign en_vec[g]    = tbl_q[g].en;
      assign wr_slot_o[g] = wr_ok && (cfg_addr == AW'(g));
    end
  end

  // R8
  woff_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && ({1'b0, cfg_woff} > (IDX_W+1)'(MAX_WOFF))) |=> $stable(en_vec));
endmodule

// File: rtl/frf_match_track.sv
module frf_match_track
  import frf_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  rule_t             rules_i [DEPTH],
  input  logic [DEPTH-1:0]  wr_slot_i,
  input  logic              frm_valid,
  input  logic [DATA_W-1:0] frm_word,
  input  logic [IDX_W-1:0]  frm_idx,
  input  logic              frm_last,
  output logic [DEPTH-1:0]  full_o
);
  localparam int LAST = DEPTH - 1;

  logic             in_frame_q;
  logic             start;
  logic [DEPTH-1:0] hit_now, ok_nx, ok_q;

  assign start = frm_valid && !in_frame_q;

  always_ff @(posedge clk) begin
    if (rst)            in_frame_q <= 1'b0;
    else if (frm_valid) in_frame_q <= !frm_last;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_rule
    assign hit_now[g] = frm_valid && word_hit(rules_i[g], frm_word, frm_idx);
    assign ok_nx[g]   = (start ? 1'b0 : ok_q[g]) | hit_now[g];

    always_ff @(posedge clk) begin
      if (rst || wr_slot_i[g]) ok_q[g] <= 1'b0;
      else if (frm_valid)      ok_q[g] <= ok_nx[g];
    end

    if (g == 0) begin : g_first
      assign full_o[g] = ok_nx[g] && !rules_i[g].link &&
                         (rules_i[g].acc || rules_i[g].rej);
    end else begin : g_chain
      assign full_o[g] = ok_nx[g] && (!rules_i[g].link || ok_nx[g-1]) &&
                         (rules_i[g].acc || rules_i[g].rej);
    end
  end

  // R7
  default_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_idx == '0) |-> hit_now[LAST]);
endmodule

// File: rtl/frf_verdict.sv
module frf_verdict #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] full_i,
  input  logic [DEPTH-1:0] rej_i,
  input  logic             frm_valid,
  input  logic             frm_last,
  output logic             vd_valid,
  output logic             vd_accept,
  output logic [AW-1:0]    vd_rule
);
  localparam int LAST = DEPTH - 1;

  logic [AW-1:0] sel;
  logic          keep;

  always_comb begin
    sel = AW'(LAST);
    for (int i = LAST; i >= 0; i--) begin
      if (full_i[i]) sel = AW'(i);
    end
    keep = !rej_i[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vd_valid  <= 1'b0;
      vd_accept <= 1'b0;
      vd_rule   <= '0;
    end else begin
      vd_valid <= frm_valid && frm_last;
      if (frm_valid && frm_last) begin
        vd_accept <= keep;
        vd_rule   <= sel;
      end
    end
  end

  // R10
  verdict_timing_chk: assert property (@(posedge clk) disable iff (rst)
    vd_valid |-> $past(frm_valid && frm_last));
  // R7
  default_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (vd_valid && vd_rule == AW'(LAST)) |-> vd_accept);
endmodule

// File: rtl/frame_rule_filter.sv
module frame_rule_filter
  import frf_pkg::*;
#(
  parameter int DEPTH         = 64,
  parameter int MAX_OFF_BYTES = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic              cfg_enable,
  input  logic              cfg_link,
  input  logic              cfg_accept,
  input  logic              cfg_reject,
  input  logic [IDX_W-1:0]  cfg_woff,
  input  logic [DATA_W-1:0] cfg_mask,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              frm_valid,
  input  logic [DATA_W-1:0] frm_word,
  input  logic [IDX_W-1:0]  frm_idx,
  input  logic              frm_last,
  output logic              vd_valid,
  output logic              vd_accept,
  output logic [AW-1:0]     vd_rule
);
  rule_t            rules [DEPTH];
  logic [DEPTH-1:0] wr_slot, full, rej_vec;

  frf_rule_table #(.DEPTH(DEPTH), .MAX_OFF_BYTES(MAX_OFF_BYTES)) u_table (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_enable(cfg_enable), .cfg_link(cfg_link), .cfg_accept(cfg_accept),
    .cfg_reject(cfg_reject), .cfg_woff(cfg_woff), .cfg_mask(cfg_mask),
    .cfg_data(cfg_data), .rules_o(rules), .wr_slot_o(wr_slot)
  );

  frf_match_track #(.DEPTH(DEPTH)) u_track (
    .clk(clk), .rst(rst), .rules_i(rules), .wr_slot_i(wr_slot),
    .frm_valid(frm_valid), .frm_word(frm_word), .frm_idx(frm_idx),
    .frm_last(frm_last), .full_o(full)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_rej
    assign rej_vec[g] = rules[g].rej;
  end

  frf_verdict #(.DEPTH(DEPTH)) u_verdict (
    .clk(clk), .rst(rst), .full_i(full), .rej_i(rej_vec),
    .frm_valid(frm_valid), .frm_last(frm_last), .vd_valid(vd_valid),
    .vd_accept(vd_accept), .vd_rule(vd_rule)
  );
endmodule

// File: tb/frame_rule_filter_tb.sv
module frame_rule_filter_tb;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int VW    = 105;
  localparam int NV    = 9;

  // {w0, w1, w2, words, expect keep, expect rule}
  localparam logic [VW-1:0] VEC [NV] = '{
    {32'hAABB1234, 32'h00000000, 32'h00000000, 2'd3, 1'b1, 6'd5},   // R2 keep
    {32'h00000000, 32'h00000800, 32'h00000000, 2'd3, 1'b0, 6'd2},   // R4 drop
    {32'hAABB0000, 32'h00000800, 32'h00000000, 2'd3, 1'b0, 6'd2},   // R3 order
    {32'h00000000, 32'h33440000, 32'h00001122, 2'd3, 1'b0, 6'd11},  // R5 pair
    {32'h00000000, 32'h33440000, 32'h00001199, 2'd3, 1'b1, 6'd63},  // R5 half
    {32'h00000000, 32'h00000000, 32'h00001122, 2'd3, 1'b1, 6'd63},  // R5 half
    {32'h00000000, 32'h00000800, 32'h00000000, 2'd1, 1'b1, 6'd63},  // R9 short
    {32'h00000000, 32'h33440000, 32'h00001122, 2'd2, 1'b1, 6'd63},  // R9 short
    {32'hAABB0000, 32'h00000000, 32'h00000000, 2'd1, 1'b1, 6'd5}    // R2 one word
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_enable = 0, cfg_link = 0, cfg_accept = 0, cfg_reject = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [7:0]  cfg_woff = '0;
  logic [31:0] cfg_mask = '0, cfg_data = '0;
  logic frm_valid = 0, frm_last = 0;
  logic [31:0] frm_word = '0;
  logic [7:0]  frm_idx = '0;
  logic vd_valid, vd_accept;
  logic [AW-1:0] vd_rule;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  frame_rule_filter #(.DEPTH(DEPTH), .MAX_OFF_BYTES(64)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_enable(cfg_enable), .cfg_link(cfg_link), .cfg_accept(cfg_accept),
    .cfg_reject(cfg_reject), .cfg_woff(cfg_woff), .cfg_mask(cfg_mask),
    .cfg_data(cfg_data), .frm_valid(frm_valid), .frm_word(frm_word),
    .frm_idx(frm_idx), .frm_last(frm_last), .vd_valid(vd_valid),
    .vd_accept(vd_accept), .vd_rule(vd_rule)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_vd(input string req, input bit acc, input int rule);
    chk(vd_valid === 1'b1, {req, " valid"}, int'(vd_valid), 1);
    chk(vd_accept === acc, {req, " keep"}, int'(vd_accept), int'(acc));
    chk(vd_rule === AW'(rule), {req, " rule"}, int'(vd_rule), rule);
  endtask

  task automatic set_cfg(input int addr, input int woff, input logic [31:0] data,
                         input logic [31:0] mask, input bit acc, input bit rej,
                         input bit link);
    cfg_we = 1; cfg_addr = AW'(addr); cfg_enable = 1; cfg_link = link;
    cfg_accept = acc; cfg_reject = rej; cfg_woff = 8'(woff);
    cfg_mask = mask; cfg_data = data;
  endtask

  task automatic wr_rule(input int addr, input int woff, input logic [31:0] data,
                         input logic [31:0] mask, input bit acc, input bit rej,
                         input bit link);
    @(negedge clk);
    set_cfg(addr, woff, data, mask, acc, rej, link);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic drive(input logic [31:0] w, input int idx, input bit last);
    frm_valid = 1; frm_word = w; frm_idx = 8'(idx); frm_last = last;
  endtask

  task automatic run_frame(input logic [31:0] w0, input logic [31:0] w1,
                           input logic [31:0] w2, input int n, input bit acc,
                           input int rule, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      drive(k == 0 ? w0 : k == 1 ? w1 : k == 2 ? w2 : 32'h0, k, k == n - 1);
    end
    @(negedge clk);
    frm_valid = 0; frm_last = 0;
    chk_vd(req, acc, rule);
    @(negedge clk);
    chk(vd_valid === 1'b0, "R10 single pulse", int'(vd_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(vd_valid === 1'b0, "R1 reset valid", int'(vd_valid), 0);
    run_frame(32'hAABB0000, 32'h00000800, 0, 3, 1'b1, 63, "R1 empty table");

    wr_rule(0, 0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b1);                       // R5 linked at slot 0
    wr_rule(2, 1, 32'h00000800, 32'h0000FFFF, 1'b0, 1'b1, 1'b0);
    wr_rule(5, 0, 32'hAABB0000, 32'hFFFF0000, 1'b1, 1'b0, 1'b0);
    wr_rule(10, 1, 32'h33440000, 32'hFFFF0000, 1'b0, 1'b0, 1'b0);
    wr_rule(11, 2, 32'h00001122, 32'h0000FFFF, 1'b0, 1'b1, 1'b1);
    wr_rule(12, 0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);                      // R6 no flags

    for (int v = 0; v < NV; v++) begin
      run_frame(VEC[v][104:73], VEC[v][72:41], VEC[v][40:9], int'(VEC[v][8:7]),
                VEC[v][6], int'(VEC[v][5:0]), $sformatf("R2/R3/R5/R6/R9 vec %0d", v));
    end

    // R7: write to reserved slot ignored
    wr_rule(63, 0, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0);
    run_frame(32'h0, 32'h0, 32'h0, 1, 1'b1, 63, "R7 reserved slot");

    // R4: both flags, discard wins
    wr_rule(5, 0, 32'hAABB0000, 32'hFFFF0000, 1'b1, 1'b1, 1'b0);
    run_frame(32'hAABB0000, 0, 0, 1, 1'b0, 5, "R4 both flags");

    // R11: write on last-word cycle uses old contents
    wr_rule(5, 0, 32'hAABB0000, 32'hFFFF0000, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    drive(32'hAABB0000, 0, 1'b1);
    set_cfg(5, 0, 32'hAABB0000, 32'hFFFF0000, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    frm_valid = 0; frm_last = 0; cfg_we = 0;
    chk_vd("R11 same cycle old rule", 1'b1, 5);
    run_frame(32'hAABB0000, 0, 0, 1, 1'b0, 5, "R11 new rule");

    // R11: mid-frame rewrite loses progress
    @(negedge clk);
    drive(32'hAABB0000, 0, 1'b0);
    @(negedge clk);
    drive(32'h0, 1, 1'b0);
    set_cfg(5, 0, 32'hAABB0000, 32'hFFFF0000, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    cfg_we = 0;
    drive(32'h0, 2, 1'b1);
    @(negedge clk);
    frm_valid = 0; frm_last = 0;
    chk_vd("R11 progress cleared", 1'b1, 63);

    // R12: back-to-back frames
    @(negedge clk);
    drive(32'hAABB0000, 0, 1'b0);
    @(negedge clk);
    drive(32'h0, 1, 1'b1);
    @(negedge clk);
    chk_vd("R12 first frame", 1'b1, 5);
    drive(32'h0, 0, 1'b1);
    @(negedge clk);
    frm_valid = 0; frm_last = 0;
    chk_vd("R12 second frame", 1'b1, 63);

    // R8: offset limit (64 bytes -> word 16)
    wr_rule(1, 17, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0);
    run_frame(0, 0, 0, 18, 1'b1, 63, "R8 over limit ignored");
    wr_rule(1, 16, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0);
    run_frame(0, 0, 0, 18, 1'b0, 1, "R8 at limit");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule